// File: doc/BRIEF.md
# Six-State Custom-Sequence Moore Counter

This block is a synchronous Moore machine that repeats a fixed loop of six 3-bit codes and moves one step on every rising clock edge. The 3-bit output is the state register itself, with no decode stage after it. This makes it useful wherever a short non-binary pattern has to come straight from flip-flops, such as a phase selector, a rotating enable pattern or a test sequence.

State is held in three J-K style bits. Each bit is a plain register whose update follows the J-K rule. Small excitation equations, derived from the loop, drive the J and K inputs of the three bits. Two of the eight 3-bit codes are outside the loop. The excitation logic brings either of them back into the loop on the next edge. A parameter selects where they land: the home code, or the place the minimal equations reach on their own.

A second parameter sets the code loaded by the synchronous, active-high reset. Its default is the home code 011.

Top module: `six_code_counter`

## Requirements
- R1: When `rst_i` is high at a rising edge, `code_o` becomes `RESET_CODE` (default 3'b011) after that edge. Reset takes priority over the J-K update.
- R2: When reset is low, each rising edge moves `code_o` one step along the loop 011, 111, 001, 010, 100, 110, and from 110 back to 011.
- R3: While `rst_i` stays high over several edges, `code_o` holds `RESET_CODE` and does not advance.
- R4: The codes 000 and 101 are outside the loop. From either one, the first edge with reset low gives a code inside the loop.
- R5: With `RECOVER_HOME`=1 (the default), both codes outside the loop go to 011. With `RECOVER_HOME`=0, 000 goes to 010 and 101 goes to 110.
- R6: Each state bit follows the J-K rule at every edge with reset low: J=0,K=0 holds; J=1,K=0 sets; J=0,K=1 clears; J=1,K=1 toggles.
- R7: The first step after reset is released happens on the first edge at which `rst_i` is low. From the default reset code, that step gives 111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| code_o | output | 3 | Current state code, taken directly from the state bits |

## Verification
The bench builds the block five times. The first instance uses the default parameters, to step through the loop and to test reset.

The other four instances set `RESET_CODE` to 000 or 101, each with `RECOVER_HOME` at 1 and at 0. Because reset can load a code outside the loop, the recovery path can be reached through the normal ports, without forcing internal state. Both landing variants are then compared against their expected codes on the first edge after reset is released, and on the edges that follow.

// File: rtl/six_code_pkg.sv
package six_code_pkg;

   localparam int CODE_W = 3;

   typedef logic [CODE_W-1:0] code_t;

   localparam code_t HOME_CODE = 3'b011;

   // Successor of each code along the loop; codes outside the loop map home.
   function automatic code_t loop_succ(input code_t c);
      code_t n;
      case (c)
         3'b011:  n = 3'b111;
         3'b111:  n = 3'b001;
         3'b001:  n = 3'b010;
         3'b010:  n = 3'b100;
         3'b100:  n = 3'b110;
         3'b110:  n = 3'b011;
         default: n = HOME_CODE;
      endcase
      return n;
   endfunction

   function automatic logic in_loop(input code_t c);
      return (c != 3'b000) && (c != 3'b101);
   endfunction

   // J-K update of a single bit.
   function automatic logic jk_step(input logic q, input logic j, input logic k);
      logic n;
      case ({j, k})
         2'b00:   n = q;
         2'b10:   n = 1'b1;
         2'b01:   n = 1'b0;
         default: n = ~q;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/jk_bank.sv
module jk_bank #(
   parameter int           W       = 3,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic [W-1:0] j_i,
   input  logic [W-1:0] k_i,
   output logic [W-1:0] q_o
);

   generate
      if (W < 1) begin : g_bad_width
         $error("jk_bank: W must be at least 1");
      end
   endgenerate

   for (genvar b = 0; b < W; b++) begin : g_bit
      logic q_r;

      always_ff @(posedge clk_i) begin
         if (rst_i) begin
            q_r <= RST_VAL[b];
         end else begin
            case ({j_i[b], k_i[b]})
               2'b00:   q_r <= q_r;
               2'b10:   q_r <= 1'b1;
               2'b01:   q_r <= 1'b0;
               default: q_r <= ~q_r;
            endcase
         end
      end

      assign q_o[b] = q_r;
   end

endmodule

// File: rtl/six_code_excite.sv
module six_code_excite
   import six_code_pkg::*;
#(
   parameter int RECOVER_HOME = 1
) (
   input  code_t q_i,
   output code_t j_o,
   output code_t k_o
);

   code_t j_min;
   code_t k_min;
   logic  orphan;

   // Minimal excitation taken from the six transitions of the loop.
   always_comb begin
      j_min[2] = q_i[1];
      k_min[2] = q_i[1];
      j_min[1] = 1'b1;
      k_min[1] = ~(q_i[2] ^ q_i[0]);
      j_min[0] = q_i[2] & q_i[1];
      k_min[0] = ~q_i[1];
   end

   // The codes 000 and 101 share: middle bit clear, outer bits equal.
   assign orphan = ~q_i[1] & ~(q_i[2] ^ q_i[0]);

   generate
      if (RECOVER_HOME != 0 && RECOVER_HOME != 1) begin : g_bad_mode
         $error("six_code_excite: RECOVER_HOME must be 0 or 1");
      end

      if (RECOVER_HOME == 1) begin : g_home
         // Outside the loop: clear Q2, set Q1 and Q0, landing on 011.
         always_comb begin
            if (orphan) begin
               j_o = 3'b011;
               k_o = 3'b100;
            end else begin
               j_o = j_min;
               k_o = k_min;
            end
         end
      end else begin : g_min
         // The minimal equations already re-enter the loop in one step.
         always_comb begin
            j_o = j_min;
            k_o = k_min;
         end
      end
   endgenerate

endmodule

// File: rtl/six_code_counter.sv
module six_code_counter
   import six_code_pkg::*;
#(
   parameter code_t RESET_CODE   = HOME_CODE,
   parameter int    RECOVER_HOME = 1
) (
   input  logic                clk_i,
   input  logic                rst_i,
   output logic [CODE_W-1:0]   code_o
);

   localparam int STATE_W = CODE_W;

   generate
      if (STATE_W != 3) begin : g_bad_state_w
         $error("six_code_counter: the loop is defined for 3-bit codes only");
      end
   endgenerate

   code_t state_w;
   code_t j_w;
   code_t k_w;

   six_code_excite #(
      .RECOVER_HOME(RECOVER_HOME)
   ) u_excite (
      .q_i(state_w),
      .j_o(j_w),
      .k_o(k_w)
   );

   jk_bank #(
      .W      (STATE_W),
      .RST_VAL(RESET_CODE)
   ) u_bits (
      .clk_i(clk_i),
      .rst_i(rst_i),
      .j_i  (j_w),
      .k_i  (k_w),
      .q_o  (state_w)
   );

   assign code_o = state_w;

endmodule

// File: rtl/six_code_counter_chk.sv
module six_code_counter_chk
   import six_code_pkg::*;
#(
   parameter code_t RESET_CODE   = HOME_CODE,
   parameter int    RECOVER_HOME = 1
) (
   input logic  clk_i,
   input logic  rst_i,
   input code_t code_i,
   input code_t j_i,
   input code_t k_i
);

   logic primed = 1'b0;

   always_ff @(posedge clk_i) primed <= 1'b1;

   // R1: an edge with reset high loads the reset code.
   assert_reset_load_R1: assert property (@(posedge clk_i)
      (primed && $past(rst_i)) |-> (code_i == RESET_CODE));

   // R2: a code inside the loop steps to its successor.
   assert_loop_step_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      (primed && !$past(rst_i) && in_loop($past(code_i)))
         |-> (code_i == loop_succ($past(code_i))));

   // R4: a code outside the loop is left within one edge.
   assert_orphan_exit_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      (primed && !$past(rst_i) && !in_loop($past(code_i))) |-> in_loop(code_i));

   // R5: landing point of the recovery, by variant.
   generate
      if (RECOVER_HOME == 1) begin : g_home_chk
         assert_orphan_home_R5: assert property (@(posedge clk_i) disable iff (rst_i)
            (primed && !$past(rst_i) && !in_loop($past(code_i)))
               |-> (code_i == HOME_CODE));
      end else begin : g_min_chk
         assert_orphan_min_R5: assert property (@(posedge clk_i) disable iff (rst_i)
            (primed && !$past(rst_i) && !in_loop($past(code_i)))
               |-> (code_i == {$past(code_i[2]), 2'b10}));
      end
   endgenerate

   // R6: every bit follows the J-K rule applied to the excitation.
   for (genvar b = 0; b < CODE_W; b++) begin : g_jk_chk
      assert_jk_rule_R6: assert property (@(posedge clk_i) disable iff (rst_i)
         (primed && !$past(rst_i))
            |-> (code_i[b] == jk_step($past(code_i[b]), $past(j_i[b]), $past(k_i[b]))));
   end

endmodule

bind six_code_counter six_code_counter_chk #(
   .RESET_CODE  (RESET_CODE),
   .RECOVER_HOME(RECOVER_HOME)
) u_chk (
   .clk_i (clk_i),
   .rst_i (rst_i),
   .code_i(code_o),
   .j_i   (j_w),
   .k_i   (k_w)
);

// File: tb/six_code_counter_tb.sv
`timescale 1ns/1ps
module six_code_counter_tb;

   localparam real HALF_NS = 2.5;
   localparam int  NSTEP   = 12;

   // Expected code after each edge following reset release (two full loops).
   localparam logic [2:0] EXP_SEQ [NSTEP] = '{
      3'b111, 3'b001, 3'b010, 3'b100, 3'b110, 3'b011,
      3'b111, 3'b001, 3'b010, 3'b100, 3'b110, 3'b011
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [2:0] code_d, code_h0, code_h5, code_m0, code_m5;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(HALF_NS) clk = ~clk;

   six_code_counter u_dut (.clk_i(clk), .rst_i(rst), .code_o(code_d));

   six_code_counter #(.RESET_CODE(3'b000), .RECOVER_HOME(1)) u_dut_h0
      (.clk_i(clk), .rst_i(rst), .code_o(code_h0));
   six_code_counter #(.RESET_CODE(3'b101), .RECOVER_HOME(1)) u_dut_h5
      (.clk_i(clk), .rst_i(rst), .code_o(code_h5));
   six_code_counter #(.RESET_CODE(3'b000), .RECOVER_HOME(0)) u_dut_m0
      (.clk_i(clk), .rst_i(rst), .code_o(code_m0));
   six_code_counter #(.RESET_CODE(3'b101), .RECOVER_HOME(0)) u_dut_m5
      (.clk_i(clk), .rst_i(rst), .code_o(code_m5));

   task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      // Reset held over three edges.
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 default reset", code_d, 3'b011);
      check("R1 reset to 000", code_h0, 3'b000);
      check("R1 reset to 101", code_h5, 3'b101);
      check("R1 reset to 000 min", code_m0, 3'b000);
      check("R1 reset to 101 min", code_m5, 3'b101);

      rst = 1'b0;
      for (int i = 0; i < NSTEP; i++) begin
         step();
         check("R2 R6 R7 loop step", code_d, EXP_SEQ[i]);
         if (i == 0) begin
            check("R4 R5 home from 000", code_h0, 3'b011);
            check("R4 R5 home from 101", code_h5, 3'b011);
            check("R4 R5 min from 000", code_m0, 3'b010);
            check("R4 R5 min from 101", code_m5, 3'b110);
         end else if (i == 1) begin
            check("R4 loop after home 000", code_h0, 3'b111);
            check("R4 loop after home 101", code_h5, 3'b111);
            check("R4 loop after min 000", code_m0, 3'b100);
            check("R4 loop after min 101", code_m5, 3'b011);
         end
      end

      // Mid-loop reset: advance to 010, then reset overrides the update.
      step(); step(); step();
      check("R2 mid loop", code_d, 3'b010);
      rst = 1'b1;
      step();
      check("R1 reset overrides update", code_d, 3'b011);
      for (int i = 0; i < 3; i++) begin
         step();
         check("R3 hold under reset", code_d, 3'b011);
      end
      rst = 1'b0;
      step();
      check("R7 first step after release", code_d, 3'b111);
      step();
      check("R2 second step after release", code_d, 3'b001);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(1000000.0);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got hang expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule